// File: doc/BRIEF.md
# Prescaled System Timer with Interrupt Status

This block sits in a chip's system-control region. It holds a free-running timer that advances once every 128 core clocks, an alarm comparator, and a pair of interrupt registers: one for status, one for enable. When the timer steps onto the programmed alarm value, the alarm status bit is raised. Two front-panel button inputs each raise their own status bit on a press. Software clears status bits by writing ones to them.

A simple register bus reaches the four registers. Only the low ten address bits are decoded, so the register window repeats every 0x400 bytes. Read data is registered and returns one cycle after the read strobe. The block drives one interrupt line, which is the OR of every status bit that is also enabled. The button inputs are assumed to be already debounced and synchronous to the core clock.

Top module: `sysctl_timer_irq`

## Requirements
- R1: After synchronous reset, timer, alarm, status and enable all read 0, `irq_out` is 0 and `bus_rdata` is 0.
- R2: The timer register (window offset 0x10) increases by exactly one every 128 clock cycles and holds its value between these steps; it wraps from 0xFFFFFFFF to 0.
- R3: Writing the timer loads the written value and restarts the prescaler, so the first increment lands on the 128th clock edge after the write edge.
- R4: The alarm register is at offset 0x14. Status bit 0 is set on the prescaler step where the timer becomes equal to the alarm value. It is not set again while the timer stays at that value, and it is not set when a timer write or an alarm write creates the equality.
- R5: The status register is at offset 0x38. Writing it clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R6: A set event and a write-one-to-clear of the same status bit in the same cycle leave that bit set.
- R7: A rising edge on `power_btn` sets status bit 11 (value 0x800). Holding the button high does not set the bit again after it is cleared.
- R8: A rising edge on `reset_btn` sets status bit 17 (value 0x20000), with the same once-per-press behaviour as R7.
- R9: The enable register is at offset 0x3C and is read/write. `irq_out` is high exactly when some status bit and the same enable bit are both 1.
- R10: Only address bits [9:0] are decoded, so every register is also reached at its offset plus any multiple of 0x400. Offsets that map to no register read as 0, and writes to them change nothing.
- R11: `bus_rdata` shows the addressed register one cycle after a cycle with `bus_rd_en` high. It is 0 after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Byte address; bits [9:0] are decoded |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| power_btn | input | 1 | Debounced power button level |
| reset_btn | input | 1 | Debounced reset button level |
| irq_out | output | 1 | Combined masked interrupt |

## Verification
A wrong prescaler count appears at the ports as a timer value read back one step early or late. This is visible at the first boundary read taken one edge before or after the 128th edge following a timer write. A corrupted status or enable bit appears on `irq_out` in the very next cycle. A lost or repeated alarm or button event shows up as a wrong status read within one prescaler period of the event. The bench keeps a cycle-level reference of the register state, computed from the requirements. It compares every read and, every cycle, the interrupt line against that reference, under directed boundary cases and under random bus traffic.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W = 32;
    localparam int WIN_W  = 10;

    localparam logic [WIN_W-1:0] OFF_TIMER  = 10'h010;
    localparam logic [WIN_W-1:0] OFF_ALARM  = 10'h014;
    localparam logic [WIN_W-1:0] OFF_ACTIVE = 10'h038;
    localparam logic [WIN_W-1:0] OFF_ENABLE = 10'h03C;

    localparam int IRQ_ALARM = 0;
    localparam int IRQ_POWER = 11;
    localparam int IRQ_RESET = 17;
    localparam int N_BTN     = 2;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TIMER,
        SEL_ALARM,
        SEL_ACTIVE,
        SEL_ENABLE
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        reg_sel_e sel;
        word_t    wdata;
    } bus_req_t;

    function automatic reg_sel_e decode_offset(input logic [WIN_W-1:0] off);
        case (off)
            OFF_TIMER:  return SEL_TIMER;
            OFF_ALARM:  return SEL_ALARM;
            OFF_ACTIVE: return SEL_ACTIVE;
            OFF_ENABLE: return SEL_ENABLE;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart || tick) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    assert_restart_zero_R3: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt_q == '0));

endmodule

// File: rtl/btn_edge.sv
module btn_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] level,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign rise[i] = level[i] & ~prev_q[i];

        assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
            rise[i] |=> !rise[i]);
    end

endmodule

// File: rtl/alarm_timer.sv
module alarm_timer
    import tmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  timer_wr,
    input  logic  alarm_wr,
    input  word_t wdata,
    output word_t timer_q,
    output word_t alarm_q,
    output logic  alarm_hit
);
    word_t timer_next;

    assign timer_next = timer_q + 1'b1;
    assign alarm_hit  = tick && !timer_wr && (timer_next == alarm_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            timer_q <= '0;
            alarm_q <= '0;
        end else begin
            if (timer_wr)  timer_q <= wdata;
            else if (tick) timer_q <= timer_next;
            if (alarm_wr)  alarm_q <= wdata;
        end
    end

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && !timer_wr) |=> (timer_q == word_t'($past(timer_q) + 1'b1)));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !timer_wr) |=> $stable(timer_q));

    assert_load_R3: assert property (@(posedge clk) disable iff (rst)
        timer_wr |=> (timer_q == $past(wdata)));

    assert_hit_lands_R4: assert property (@(posedge clk) disable iff (rst)
        alarm_hit |=> (timer_q == $past(alarm_q)));

endmodule

// File: rtl/irq_status.sv
module irq_status
    import tmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t set_vec,
    input  logic  clr_wr,
    input  logic  en_wr,
    input  word_t wdata,
    output word_t status_q,
    output word_t enable_q,
    output logic  irq
);
    word_t clr_mask;

    assign clr_mask = clr_wr ? wdata : '0;
    assign irq      = |(status_q & enable_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_mask) | set_vec;
            if (en_wr) enable_q <= wdata;
        end
    end

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

    assert_quiet_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!clr_wr && set_vec == '0) |=> $stable(status_q));

endmodule

// File: rtl/sysctl_timer_irq.sv
module sysctl_timer_irq
    import tmr_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int PRESCALE = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd_en,
    output logic [31:0]       bus_rdata,
    input  logic              power_btn,
    input  logic              reset_btn,
    output logic              irq_out
);
    bus_req_t req;
    logic     unused_addr_hi;

    assign unused_addr_hi = ^bus_addr[ADDR_W-1:WIN_W];

    always_comb begin
        req.wr    = bus_wr_en;
        req.rd    = bus_rd_en;
        req.sel   = decode_offset(bus_addr[WIN_W-1:0]);
        req.wdata = bus_wdata;
    end

    logic tick;
    tick_prescaler #(.DIV(PRESCALE)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .restart (req.wr && req.sel == SEL_TIMER),
        .tick    (tick)
    );

    word_t timer_q, alarm_q;
    logic  alarm_hit;
    alarm_timer u_timer (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .timer_wr  (req.wr && req.sel == SEL_TIMER),
        .alarm_wr  (req.wr && req.sel == SEL_ALARM),
        .wdata     (req.wdata),
        .timer_q   (timer_q),
        .alarm_q   (alarm_q),
        .alarm_hit (alarm_hit)
    );

    logic [N_BTN-1:0] btn_rise;
    btn_edge #(.N(N_BTN)) u_btn (
        .clk   (clk),
        .rst   (rst),
        .level ({reset_btn, power_btn}),
        .rise  (btn_rise)
    );

    word_t set_vec;
    always_comb begin
        set_vec            = '0;
        set_vec[IRQ_ALARM] = alarm_hit;
        set_vec[IRQ_POWER] = btn_rise[0];
        set_vec[IRQ_RESET] = btn_rise[1];
    end

    word_t status_q, enable_q;
    irq_status u_irq (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (set_vec),
        .clr_wr   (req.wr && req.sel == SEL_ACTIVE),
        .en_wr    (req.wr && req.sel == SEL_ENABLE),
        .wdata    (req.wdata),
        .status_q (status_q),
        .enable_q (enable_q),
        .irq      (irq_out)
    );

    word_t rd_mux;
    always_comb begin
        case (req.sel)
            SEL_TIMER:  rd_mux = timer_q;
            SEL_ALARM:  rd_mux = alarm_q;
            SEL_ACTIVE: rd_mux = status_q;
            SEL_ENABLE: rd_mux = enable_q;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (req.rd) bus_rdata <= rd_mux;
        else             bus_rdata <= '0;
    end

    assert_mask_off_R9: assert property (@(posedge clk) disable iff (rst)
        (enable_q == '0) |-> !irq_out);

    assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_en |=> (bus_rdata == '0));

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_en && req.sel == SEL_NONE) |=> (bus_rdata == '0));

endmodule

// File: tb/test_sysctl_timer_irq.sv
module test_sysctl_timer_irq;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] bus_addr;
    logic        bus_wr_en;
    logic [31:0] bus_wdata;
    logic        bus_rd_en;
    logic [31:0] bus_rdata;
    logic        power_btn;
    logic        reset_btn;
    logic        irq_out;

    always #10 clk = ~clk;

    sysctl_timer_irq i_sysctl_timer_irq (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr_en (bus_wr_en),
        .bus_wdata (bus_wdata),
        .bus_rd_en (bus_rd_en),
        .bus_rdata (bus_rdata),
        .power_btn (power_btn),
        .reset_btn (reset_btn),
        .irq_out   (irq_out)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit irq_watch = 1'b0;

    // Reference state, computed from the requirements
    logic [31:0] m_timer, m_alarm, m_status, m_en, exp_rd;
    int          m_presc;
    logic        m_pp, m_rp;

    function automatic logic [31:0] model_read(input logic [31:0] a);
        case (a[9:0])
            10'h010: return m_timer;
            10'h014: return m_alarm;
            10'h038: return m_status;
            10'h03C: return m_en;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [31:0] sets;
        logic [9:0]  off;
        off = bus_addr[9:0];
        if (rst) begin
            m_timer = 0; m_alarm = 0; m_status = 0; m_en = 0;
            m_presc = 0; m_pp = 0; m_rp = 0; exp_rd = 0;
        end else begin
            exp_rd = bus_rd_en ? model_read(bus_addr) : 32'h0;
            sets = 32'h0;
            if (bus_wr_en && off == 10'h010) begin
                m_timer = bus_wdata;
                m_presc = 0;
            end else if (m_presc == 127) begin
                m_presc = 0;
                m_timer = m_timer + 1;
                if (m_timer == m_alarm) sets[0] = 1'b1;
            end else begin
                m_presc = m_presc + 1;
            end
            if (power_btn && !m_pp) sets[11] = 1'b1;
            if (reset_btn && !m_rp) sets[17] = 1'b1;
            m_pp = power_btn;
            m_rp = reset_btn;
            if (bus_wr_en && off == 10'h038) m_status = m_status & ~bus_wdata;
            m_status = m_status | sets;
            if (bus_wr_en && off == 10'h014) m_alarm = bus_wdata;
            if (bus_wr_en && off == 10'h03C) m_en = bus_wdata;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (irq_watch) chk("R9 irq_out", {31'h0, irq_out}, {31'h0, |(m_status & m_en)});
    end

    task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [31:0] a, input string tag, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1'b1;
        @(negedge clk);
        bus_rd_en = 1'b0;
        chk(tag, bus_rdata, exp_rd);
        v = bus_rdata;
    endtask

    function automatic string tag_of(input logic [31:0] a);
        case (a[9:0])
            10'h010: return "R2 timer";
            10'h014: return "R10 alarm";
            10'h038: return "R5 status";
            10'h03C: return "R9 enable";
            default: return "R10 unmapped";
        endcase
    endfunction

    initial begin
        #(20 * 200000);
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4711));
        rst = 1'b1; bus_addr = 0; bus_wr_en = 0; bus_wdata = 0; bus_rd_en = 0;
        power_btn = 0; reset_btn = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        irq_watch = 1'b1;

        // R1: reset state
        chk("R1 rdata", bus_rdata, 32'h0);
        chk("R1 irq", {31'h0, irq_out}, 32'h0);
        bus_rd(32'h10, "R1 timer", v);  chk("R1 timer", v, 32'h0);
        bus_rd(32'h14, "R1 alarm", v);  chk("R1 alarm", v, 32'h0);
        bus_rd(32'h38, "R1 status", v); chk("R1 status", v, 32'h0);
        bus_rd(32'h3C, "R1 enable", v); chk("R1 enable", v, 32'h0);

        // R11: idle cycle after a read gives zero
        @(negedge clk);
        chk("R11 idle rdata", bus_rdata, 32'h0);

        // R3 / R2: load and exact step boundaries (write edge E0)
        bus_wr(32'h10, 32'd100);
        repeat (125) @(negedge clk);
        bus_rd(32'h10, "R3 before first step", v); chk("R3 before first step", v, 32'd100);
        bus_rd(32'h10, "R3 first step", v);        chk("R3 first step", v, 32'd101);
        repeat (124) @(negedge clk);
        bus_rd(32'h10, "R2 before second step", v); chk("R2 before second step", v, 32'd101);
        bus_rd(32'h10, "R2 second step", v);        chk("R2 second step", v, 32'd102);

        // R2: wrap
        bus_wr(32'h10, 32'hFFFF_FFFF);
        repeat (130) @(negedge clk);
        bus_rd(32'h10, "R2 wrap", v); chk("R2 wrap", v, 32'h0);

        // R4: alarm fires once, no refire while equal, no fire on write-made equality
        bus_wr(32'h14, 32'd200);
        bus_wr(32'h10, 32'd198);
        bus_wr(32'h38, 32'hFFFF_FFFF);
        repeat (270) @(negedge clk);
        bus_rd(32'h38, "R4 alarm set", v); chk("R4 alarm set", v & 32'h1, 32'h1);
        bus_wr(32'h38, 32'h1);
        repeat (20) @(negedge clk);
        bus_rd(32'h38, "R4 no refire", v); chk("R4 no refire", v & 32'h1, 32'h0);
        bus_wr(32'h10, 32'd200);
        repeat (5) @(negedge clk);
        bus_rd(32'h38, "R4 write equal", v); chk("R4 write equal", v & 32'h1, 32'h0);

        // R7 / R8 / R5: buttons and write-one-to-clear
        bus_wr(32'h3C, 32'h0);
        @(negedge clk); power_btn = 1'b1;
        bus_rd(32'h38, "R7 power", v); chk("R7 power", v, 32'h800);
        chk("R9 masked", {31'h0, irq_out}, 32'h0);
        @(negedge clk); reset_btn = 1'b1;
        bus_rd(32'h38, "R8 reset", v); chk("R8 reset", v, 32'h20800);
        bus_wr(32'h38, 32'h800);
        bus_rd(32'h38, "R5 partial clear", v); chk("R5 partial clear", v, 32'h20000);
        repeat (10) @(negedge clk);
        bus_rd(32'h38, "R7 held", v); chk("R7 held", v, 32'h20000);
        bus_wr(32'h38, 32'h20000);
        bus_rd(32'h38, "R8 held", v); chk("R8 held", v, 32'h0);
        @(negedge clk); power_btn = 1'b0; reset_btn = 1'b0;

        // R6: set and clear of bit 11 in the same cycle
        @(negedge clk);
        power_btn = 1'b1; bus_addr = 32'h38; bus_wdata = 32'h800; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
        bus_rd(32'h38, "R6 set wins", v); chk("R6 set wins", v & 32'h800, 32'h800);

        // R9: enable masks output
        bus_wr(32'h3C, 32'h800);
        @(negedge clk);
        chk("R9 enabled", {31'h0, irq_out}, 32'h1);
        bus_wr(32'h3C, 32'h1);
        @(negedge clk);
        chk("R9 other bit", {31'h0, irq_out}, 32'h0);
        bus_wr(32'h38, 32'hFFFF_FFFF);
        power_btn = 1'b0;

        // R10: mirroring and unmapped offsets
        bus_wr(32'h0000_0414, 32'h1234);
        bus_rd(32'h14, "R10 mirror write", v); chk("R10 mirror write", v, 32'h1234);
        bus_rd(32'hABCD_FC14, "R10 mirror read", v); chk("R10 mirror read", v, 32'h1234);
        bus_wr(32'h20, 32'hDEAD_BEEF);
        bus_rd(32'h20, "R10 unmapped", v); chk("R10 unmapped", v, 32'h0);
        bus_rd(32'h14, "R10 unmapped write", v); chk("R10 unmapped write", v, 32'h1234);

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] hi, a;
            hi = {$urandom} & 32'hFFFF_FC00;
            case ($urandom % 9)
                0: bus_wr(hi | 32'h10, ($urandom % 4 == 0) ? $urandom : m_timer + ($urandom % 3));
                1: bus_wr(hi | 32'h14, m_timer + ($urandom % 3));
                2: bus_wr(hi | 32'h38, $urandom);
                3: bus_wr(hi | 32'h3C, $urandom);
                4, 5: begin
                    case ($urandom % 5)
                        0: a = 32'h10; 1: a = 32'h14; 2: a = 32'h38;
                        3: a = 32'h3C; default: a = 32'h0 | (($urandom % 256) << 2);
                    endcase
                    a = hi | a;
                    bus_rd(a, tag_of(a), v);
                end
                6: begin @(negedge clk); power_btn = $urandom; end
                7: begin @(negedge clk); reset_btn = $urandom; end
                default: repeat ($urandom % 40) @(negedge clk);
            endcase
        end

        irq_watch = 1'b0;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule